// File: doc/BRIEF.md
# Pen-Down Rate-Limited Sampling Trigger

This block sits between a touch panel's pen-down interrupt line and the engine that runs the ADC scans. The pen line is a level signal. Its level also moves whenever the converter switches channels. The block turns each pen-down event into a train of one-cycle trigger pulses, spaced one scan interval apart. It masks the pen line while scans would disturb it. When the pen lifts, it keeps sampling for a bounded number of further intervals and then returns to a low-power idle state, where it waits for the next pen-down.

A programmable microsecond countdown sets the pace. The sampling engine returns a one-cycle `scan_done` pulse after every scan. That pulse arms the countdown for the interval minus the scan duration. After a fixed number of polls since the last pen event, the pen line is opened again, so that a pen that stays down restarts the train. The block has no data path: every pin is a plain control or status signal, and it carries no valid/ready handshake. A typical setting is an interval of 10000 µs.

Top module: `pen_irq_trigger`

## Requirements
- R1: After reset the block is off: `irq_mask` is 1 and `trig` is 0.
- R2: While `en` is 0 the block is off, with `irq_mask` = 1 and no pending countdown. In the cycle after `en` is seen high in the off state, the block goes idle with `irq_mask` = 0. Dropping `en` in any state cancels all further triggers.
- R3: A high `pen_irq` that the block samples while not off and with `irq_mask` = 0 does all of the following:
  - cancels the countdown;
  - clears the poll count;
  - sets `irq_mask` = 1;
  - pulses `trig` in the next cycle.
- R4: `pen_irq` has no effect while `irq_mask` = 1 or while `en` = 0.
- R5: A sampled `scan_done` (block not off) loads the countdown with `interval_us - scan_us`, or with 0 if `scan_us` is not smaller than `interval_us`. When `us_tick` is high every cycle, a load of N made at one clock edge expires at the N+1-th edge after it.
- R6: An expiry while waiting after a scan, with a poll count below 6, does two things: it increments the count and it reloads the full `interval_us`. The new count then decides the mask. If the new count is 3 or more, `irq_mask` goes to 0. If it is 1 or 2, `irq_mask` stays 1.
- R7: An expiry of that full-interval wait sets `irq_mask` = 1 (if it was open) and pulses `trig`. The block then waits for the next `scan_done`.
- R8: An expiry while waiting after a scan with the poll count at 6 returns the block to idle with `irq_mask` = 0. An isolated pen event therefore gives exactly 7 triggers.
- R9: An expiry while idle changes nothing: there is no trigger and `irq_mask` stays 0.
- R10: `trig` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Level enable; low forces the off state |
| pen_irq | input | 1 | Pen-down interrupt level, active high |
| scan_done | input | 1 | One-cycle pulse when a triggered scan finishes |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| interval_us | input | TW | Scan interval in microseconds |
| scan_us | input | TW | Duration of one scan in microseconds |
| trig | output | 1 | One-cycle trigger for the scan engine |
| irq_mask | output | 1 | 1 while the pen interrupt is ignored |

## Verification
The bench builds the block with its default 16-bit countdown and holds `us_tick` high every cycle. It sets an interval of 20 and a scan time of 5, and answers each trigger with `scan_done` four cycles later. These values fit a whole seven-trigger train, with its 42-cycle spacing, into a few hundred cycles. The re-opened mask window, a re-armed pen event and a mid-train disable can then all be reached on exact cycles. A second run with a scan time of 30 drives the saturating reload to zero.

// File: rtl/pen_trig_pkg.sv
package pen_trig_pkg;
  typedef enum logic [2:0] {
    PT_OFF,       // disabled, pen line masked
    PT_IDLE,      // waiting for pen-down, pen line open
    PT_SETTLE,    // scan issued, waiting for post-scan expiry
    PT_GAP,       // full-interval wait, pen line masked
    PT_GAP_OPEN   // full-interval wait, pen line open
  } pt_state_e;
endpackage

// File: rtl/pen_trig_reload.sv
module pen_trig_reload #(
  parameter int TW = 16
) (
  input  logic [TW-1:0] interval_us,
  input  logic [TW-1:0] scan_us,
  input  logic          full,
  output logic [TW-1:0] value
);
  always_comb begin
    if (full)
      value = interval_us;
    else if (scan_us >= interval_us)
      value = '0;
    else
      value = interval_us - scan_us;
  end
endmodule

// File: rtl/pen_trig_timer.sv
module pen_trig_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          cancel,
  output logic          expire
);
  logic          armed;
  logic [TW-1:0] remain;

  assign expire = armed && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (cancel) begin
      armed  <= 1'b0;
    end else if (load) begin
      armed  <= 1'b1;
      remain <= load_val;
    end else if (expire) begin
      armed  <= 1'b0;
    end else if (armed && tick) begin
      remain <= remain - 1'b1;
    end
  end

  // R2/R3: a cancel leaves nothing to expire in the following cycle
  p_cancel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !expire);
endmodule

// File: rtl/pen_trig_ctrl.sv
module pen_trig_ctrl
  import pen_trig_pkg::*;
#(
  parameter int POLL_MIN = 3,
  parameter int POLL_MAX = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pen_irq,
  input  logic scan_done,
  input  logic expire,
  output logic trig,
  output logic irq_mask,
  output logic tmr_load,
  output logic tmr_full,
  output logic tmr_cancel
);
  localparam int CW = $clog2(POLL_MAX + 1);

  pt_state_e     state;
  logic [CW-1:0] polls;
  logic [CW-1:0] polls_nx;
  logic          irq_evt;
  logic          settle_more;

  assign irq_evt     = en && (state != PT_OFF) && !irq_mask && pen_irq;
  assign settle_more = expire && (state == PT_SETTLE) && (polls < CW'(POLL_MAX));
  assign polls_nx    = polls + 1'b1;
  assign tmr_cancel  = !en || irq_evt;
  assign tmr_full    = settle_more;
  assign tmr_load    = settle_more || (scan_done && state != PT_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PT_OFF;
      irq_mask <= 1'b1;
      polls    <= '0;
      trig     <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (!en) begin
        state    <= PT_OFF;
        irq_mask <= 1'b1;
      end else if (state == PT_OFF) begin
        state    <= PT_IDLE;
        irq_mask <= 1'b0;
      end else if (irq_evt) begin
        state    <= PT_SETTLE;
        polls    <= '0;
        irq_mask <= 1'b1;
        trig     <= 1'b1;
      end else if (expire) begin
        case (state)
          PT_SETTLE: begin
            if (settle_more) begin
              polls <= polls_nx;
              if (polls_nx >= CW'(POLL_MIN)) begin
                state    <= PT_GAP_OPEN;
                irq_mask <= 1'b0;
              end else begin
                state <= PT_GAP;
              end
            end else begin
              state    <= PT_IDLE;
              irq_mask <= 1'b0;
            end
          end
          PT_GAP_OPEN: begin
            irq_mask <= 1'b1;
            trig     <= 1'b1;
            state    <= PT_SETTLE;
          end
          PT_GAP: begin
            trig  <= 1'b1;
            state <= PT_SETTLE;
          end
          default: ;
        endcase
      end
    end
  end

  p_trig_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  p_pen_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> (trig && irq_mask && polls == '0));
  p_off_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (irq_mask && state == PT_OFF && !trig));
  p_idle_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PT_IDLE && expire && en && !irq_evt) |=> (state == PT_IDLE && !trig));
  p_open_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_more && en && !irq_evt && polls == CW'(POLL_MIN - 1)) |=> !irq_mask);
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= CW'(POLL_MAX));
endmodule

// File: rtl/pen_irq_trigger.sv
module pen_irq_trigger #(
  parameter int TW       = 16,
  parameter int POLL_MIN = 3,
  parameter int POLL_MAX = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pen_irq,
  input  logic          scan_done,
  input  logic          us_tick,
  input  logic [TW-1:0] interval_us,
  input  logic [TW-1:0] scan_us,
  output logic          trig,
  output logic          irq_mask
);
  logic          expire;
  logic          tmr_load;
  logic          tmr_full;
  logic          tmr_cancel;
  logic [TW-1:0] load_val;

  pen_trig_reload #(.TW(TW)) u_reload (
    .interval_us (interval_us),
    .scan_us     (scan_us),
    .full        (tmr_full),
    .value       (load_val)
  );

  pen_trig_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .load     (tmr_load),
    .load_val (load_val),
    .cancel   (tmr_cancel),
    .expire   (expire)
  );

  pen_trig_ctrl #(.POLL_MIN(POLL_MIN), .POLL_MAX(POLL_MAX)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .pen_irq    (pen_irq),
    .scan_done  (scan_done),
    .expire     (expire),
    .trig       (trig),
    .irq_mask   (irq_mask),
    .tmr_load   (tmr_load),
    .tmr_full   (tmr_full),
    .tmr_cancel (tmr_cancel)
  );

  // R1: the mask is set in the first cycle after reset
  p_reset_mask_r1: assert property (@(posedge clk)
    !rst_n |=> irq_mask && !trig);
endmodule

// File: tb/sim_pen_irq_trigger.sv
module sim_pen_irq_trigger;
  localparam int TW = 16;
  localparam int IV = 20;
  localparam int SC = 5;
  localparam int DL = 4;
  localparam int GV = IV - SC;
  localparam int PER = 2 * IV - SC + DL + 3;
  localparam int PER_SAT = IV + DL + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic pen = 1'b0;
  logic scan_done = 1'b0;
  logic us_tick = 1'b1;
  logic [TW-1:0] ival = TW'(IV);
  logic [TW-1:0] sval = TW'(SC);
  logic trig;
  logic irq_mask;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  int mon_e;
  string mon_r;
  bit auto_scan = 1'b1;

  pen_irq_trigger #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pen_irq(pen), .scan_done(scan_done),
    .us_tick(us_tick), .interval_us(ival), .scan_us(sval),
    .trig(trig), .irq_mask(irq_mask)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // driver: raise pen for one cycle and queue the expected trigger cycles
  task automatic pen_burst(input int n, input int per, input string tag, output int c0);
    c0 = cyc;
    pen = 1'b1;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(c0 + 1 + k * per);
      tag_q.push_back(k == 0 ? tag : "R7 poll trigger");
    end
    @(negedge clk);
    pen = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && trig) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected trigger at cycle", cyc, -1);
      end else begin
        mon_e = exp_q.pop_front();
        mon_r = tag_q.pop_front();
        chk(cyc == mon_e, mon_r, cyc, mon_e);
      end
    end
  end

  // scan engine model: answer each trigger after DL cycles
  initial begin
    forever begin
      @(negedge clk);
      if (trig && auto_scan) begin
        repeat (DL) @(negedge clk);
        scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int c0;
    int c1;
    int c2;
    repeat (3) @(negedge clk);
    chk(irq_mask == 1'b1, "R1 mask in reset", irq_mask, 1);
    chk(trig == 1'b0, "R1 trig in reset", trig, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_mask == 1'b1, "R2 mask while disabled", irq_mask, 1);
    en = 1'b1;
    @(negedge clk);
    chk(irq_mask == 1'b0, "R2 mask open after enable", irq_mask, 0);

    // isolated pen event: 7 triggers
    pen_burst(7, PER, "R3 first trigger", c0);
    wait_cyc(c0 + 3);
    chk(irq_mask == 1'b1, "R3 mask set after pen event", irq_mask, 1);
    pen = 1'b1;  // masked: must be ignored (R4)
    @(negedge clk);
    pen = 1'b0;
    wait_cyc(c0 + 1 + DL + GV + 2);
    chk(irq_mask == 1'b1, "R6 mask kept after poll 1", irq_mask, 1);
    wait_cyc(c0 + 1 + 2 * PER + DL + GV + 1);
    chk(irq_mask == 1'b1, "R6 mask before poll 3", irq_mask, 1);
    @(negedge clk);
    chk(irq_mask == 1'b0, "R6 mask open at poll 3", irq_mask, 0);
    wait_cyc(c0 + 1 + 6 * PER + DL + GV + 1);
    chk(irq_mask == 1'b1, "R8 mask before return to idle", irq_mask, 1);
    @(negedge clk);
    chk(irq_mask == 1'b0, "R8 mask open in idle", irq_mask, 0);
    repeat (3 * PER) @(negedge clk);
    chk(exp_q.size() == 0, "R8 trigger count", exp_q.size(), 0);

    // expiry while idle (R9)
    scan_done = 1'b1;
    @(negedge clk);
    scan_done = 1'b0;
    repeat (GV + 6) @(negedge clk);
    chk(irq_mask == 1'b0, "R9 idle expiry keeps mask open", irq_mask, 0);

    // pen event re-armed while the window is open (R3)
    pen_burst(3, PER, "R3 second burst first trigger", c1);
    wait_cyc(c1 + 1 + 2 * PER + DL + GV + 2);
    chk(irq_mask == 1'b0, "R6 window open in second burst", irq_mask, 0);
    pen_burst(7, PER, "R3 re-armed trigger", c2);
    wait_cyc(c2 + 1 + 6 * PER + DL + GV + 3 + PER);
    chk(exp_q.size() == 0, "R3 re-armed train length", exp_q.size(), 0);

    // disable mid-train (R2), pen ignored while off (R4)
    pen_burst(2, PER, "R3 third burst first trigger", c0);
    wait_cyc(c0 + 1 + PER + 2);
    en = 1'b0;
    @(negedge clk);
    chk(irq_mask == 1'b1, "R2 mask after disable", irq_mask, 1);
    pen = 1'b1;
    repeat (3) @(negedge clk);
    pen = 1'b0;
    repeat (3 * PER) @(negedge clk);
    chk(exp_q.size() == 0, "R2 no triggers after disable", exp_q.size(), 0);
    en = 1'b1;
    @(negedge clk);
    chk(irq_mask == 1'b0, "R2 mask open on re-enable", irq_mask, 0);

    // scan longer than interval: reload saturates to 0 (R5)
    sval = TW'(30);
    pen_burst(7, PER_SAT, "R5 saturated first trigger", c0);
    wait_cyc(c0 + 1 + 6 * PER_SAT + DL + 3);
    chk(irq_mask == 1'b0, "R5 saturated train back to idle", irq_mask, 0);
    repeat (2 * PER) @(negedge clk);
    chk(exp_q.size() == 0, "R5 saturated trigger count", exp_q.size(), 0);

    finish_run();
  end
endmodule